// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block settles the outcome of a conditional branch instruction. Each cycle it takes a 32-bit instruction word, the address of that instruction, the 32-bit condition register and the 32-bit count register. It picks out the option, condition-index, displacement and address-mode fields. It decrements the count when the option field asks for a counted loop, and it tests the chosen condition bit against a required polarity. The result one cycle later is a taken flag, the target address, the updated count and a link-register write.

A surrounding core feeds one candidate instruction per cycle and reads the registered results on the next cycle. Words whose primary opcode is not the conditional-branch code leave the count alone and raise neither taken nor the link strobe. All bit positions below count bit 0 as the most significant bit of the instruction, so opcode = `instr[31:26]`, option = `instr[25:21]`, condition index = `instr[20:16]`, displacement = `instr[15:2]`, absolute flag = `instr[1]`, link flag = `instr[0]`. Inside the 5-bit option field, "option bit k" means `bo[4-k]`.

Top module: `cbr_unit`

## Requirements
- R1: Outputs are registered. `out_valid` is 1 in the cycle after one in which `instr[31:26]` equals 16. For any other opcode, the next cycle shows `out_valid`=0, `taken`=0, `lr_we`=0 and `ctr_next` equal to the sampled `ctr`.
- R2: The fields are option `bo`=`instr[25:21]`, condition index `bi`=`instr[20:16]`, displacement `bd`=`instr[15:2]`, absolute flag `instr[1]` and link flag `instr[0]`.
- R3: When `bo[4]`=0 the tested bit is `cr[31-bi]`, and the condition passes only if that bit equals `bo[3]`. When `bo[4]`=1 the condition always passes.
- R4: When `bo[2]`=0, `ctr_next` = `ctr`-1 modulo 2^32, so 0 wraps to 0xFFFFFFFF. When `bo[2]`=1, `ctr_next` = `ctr`.
- R5: When `bo[2]`=0 the count test uses the decremented value. With `bo[1]`=0 it passes if that value is nonzero; with `bo[1]`=1 it passes if that value is zero. When `bo[2]`=1 the count test always passes.
- R6: `taken` is 1 only for a valid branch whose count test and condition test both pass.
- R7: Any option value matching 1z1zz (`bo[4]`=1 and `bo[2]`=1) is taken and leaves the count unchanged.
- R8: The hint and don't-care bits do not change the outcome. These are `bo[0]` always, `bo[1]` when `bo[2]`=1, and `bo[3]` when `bo[4]`=1.
- R9: The displacement is `{bd,2'b00}` sign-extended to 32 bits. `target` equals it when `instr[1]`=1, and equals the instruction address plus it when `instr[1]`=0.
- R10: For a valid branch with `instr[0]`=1, `lr_we`=1 and `lr_data` = instruction address + 4, whether or not the branch is taken.
- R11: With `rst_n` low at a clock edge, every output is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Candidate instruction word |
| pc | input | 32 | Address of the instruction |
| cr | input | 32 | Condition register |
| ctr | input | 32 | Count register |
| out_valid | output | 1 | Previous word was a conditional branch |
| taken | output | 1 | Branch resolved as taken |
| target | output | 32 | Branch target address |
| ctr_next | output | 32 | Count register value after the instruction |
| lr_we | output | 1 | Link-register write strobe |
| lr_data | output | 32 | Return address to write |

## Verification
The hardest case is a count of zero under a decrementing option. The count then wraps to all ones, which reverses the outcome of both the zero test and the nonzero test. Few programs reach it on purpose, so the vector table loads `ctr`=0 directly with both test polarities. It also covers the 1-to-0 step and the don't-care option bits, flipped against otherwise identical words.

// File: rtl/cbr_pkg.sv
// Shared definitions for the conditional branch resolution unit.
// Assumes 32-bit instruction words with field bit 0 at the MSB.
package cbr_pkg;
    localparam int INSN_W   = 32;
    localparam int OPC_W    = 6;
    localparam int OPT_W    = 5;
    localparam int IDX_W    = 5;
    localparam int DISP_W   = 14;
    localparam logic [OPC_W-1:0] OPC_CBRANCH = 6'd16;

    // Decoded instruction fields
    typedef struct packed {
        logic [OPT_W-1:0]  bo;
        logic [IDX_W-1:0]  bi;
        logic [DISP_W-1:0] bd;
        logic              aa;
        logic              lk;
    } br_fields_t;
endpackage

// File: rtl/cbr_decode.sv
// Field extractor: splits the instruction word and flags the branch opcode.
// Assumes the standard 32-bit layout; purely combinational.
module cbr_decode
    import cbr_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output logic              hit,
    output br_fields_t        fld
);
    // Opcode match and field split
    always_comb begin
        hit    = (instr[INSN_W-1 -: OPC_W] == OPC_CBRANCH);
        fld.bo = instr[25:21];
        fld.bi = instr[20:16];
        fld.bd = instr[15:2];
        fld.aa = instr[1];
        fld.lk = instr[0];
    end
endmodule

// File: rtl/cbr_cond_eval.sv
// Count decrement and taken-condition evaluator.
// Assumes the condition register is numbered MSB-first (index 0 = bit 31).
module cbr_cond_eval
    import cbr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int CR_W  = 32
) (
    input  logic [OPT_W-1:0] bo,
    input  logic [IDX_W-1:0] bi,
    input  logic [CR_W-1:0]  cr,
    input  logic [CNT_W-1:0] ctr,
    output logic [CNT_W-1:0] ctr_new,
    output logic             pass
);
    logic [IDX_W-1:0] cr_pos;
    logic             cr_bit;
    logic             cnt_ok;
    logic             cond_ok;

    // Decrement, select the condition bit and combine both tests
    always_comb begin
        ctr_new = bo[2] ? ctr : ctr - CNT_W'(1);
        cr_pos  = ~bi;                      // 31 - bi for a 5-bit index
        cr_bit  = cr[cr_pos];
        cnt_ok  = bo[2] | ((ctr_new == '0) == bo[1]);
        cond_ok = bo[4] | (cr_bit == bo[3]);
        pass    = cnt_ok & cond_ok;
    end
endmodule

// File: rtl/cbr_target.sv
// Target and return-address generator.
// Shares one adder: the base is zero for absolute targets.
module cbr_target
    import cbr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int INSN_STEP = 4
) (
    input  logic [DISP_W-1:0] bd,
    input  logic              aa,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] tgt,
    output logic [ADDR_W-1:0] link
);
    localparam int OFF_W = DISP_W + 2;

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] base;

    // Sign-extend word displacement and add to the selected base
    always_comb begin
        offset = {{(ADDR_W-OFF_W){bd[DISP_W-1]}}, bd, 2'b00};
        base   = aa ? '0 : pc;
        tgt    = base + offset;
        link   = pc + ADDR_W'(INSN_STEP);
    end
endmodule

// File: rtl/cbr_unit.sv
// Conditional branch resolution unit, top level.
// Resolves one candidate instruction per cycle; results appear one cycle later.
// Assumes synchronous active-low reset.
module cbr_unit
    import cbr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 32,
    parameter int CR_W      = 32,
    parameter int INSN_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] instr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [CR_W-1:0]   cr,
    input  logic [CNT_W-1:0]  ctr,
    output logic              out_valid,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic [CNT_W-1:0]  ctr_next,
    output logic              lr_we,
    output logic [ADDR_W-1:0] lr_data
);
    logic              dec_hit;
    br_fields_t        dec_fld;
    logic [CNT_W-1:0]  ev_ctr;
    logic              ev_pass;
    logic [ADDR_W-1:0] tg_addr;
    logic [ADDR_W-1:0] tg_link;

    cbr_decode u_dec (
        .instr (instr),
        .hit   (dec_hit),
        .fld   (dec_fld)
    );

    cbr_cond_eval #(.CNT_W(CNT_W), .CR_W(CR_W)) u_eval (
        .bo      (dec_fld.bo),
        .bi      (dec_fld.bi),
        .cr      (cr),
        .ctr     (ctr),
        .ctr_new (ev_ctr),
        .pass    (ev_pass)
    );

    cbr_target #(.ADDR_W(ADDR_W), .INSN_STEP(INSN_STEP)) u_tgt (
        .bd   (dec_fld.bd),
        .aa   (dec_fld.aa),
        .pc   (pc),
        .tgt  (tg_addr),
        .link (tg_link)
    );

    // Register the resolved outcome; non-branch words pass the count through
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            target    <= '0;
            ctr_next  <= '0;
            lr_we     <= 1'b0;
            lr_data   <= '0;
        end else begin
            out_valid <= dec_hit;
            taken     <= dec_hit & ev_pass;
            target    <= tg_addr;
            ctr_next  <= dec_hit ? ev_ctr : ctr;
            lr_we     <= dec_hit & dec_fld.lk;
            lr_data   <= tg_link;
        end
    end
endmodule

// File: rtl/cbr_unit_chk.sv
// Protocol checker for cbr_unit, attached by bind. Observes only.
module cbr_unit_chk #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 32,
    parameter int INSN_STEP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hit_i,
    input logic [4:0]        bo_i,
    input logic              lk_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [CNT_W-1:0]  ctr_i,
    input logic              out_valid,
    input logic              taken,
    input logic [CNT_W-1:0]  ctr_next,
    input logic              lr_we,
    input logic [ADDR_W-1:0] lr_data
);
    // R1: a non-branch word yields a quiet output
    a_r1_nonbranch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !hit_i) |-> (!out_valid && !taken && !lr_we && ctr_next == $past(ctr_i)));

    // R6: taken only accompanies a valid result
    a_r6_taken_valid: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> out_valid);

    // R4: count held when decrement disabled
    a_r4_ctr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && hit_i && bo_i[2]) |-> ctr_next == $past(ctr_i));

    // R4: count decremented with wrap
    a_r4_ctr_dec: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && hit_i && !bo_i[2]) |-> ctr_next == $past(ctr_i) - CNT_W'(1));

    // R7: branch-always form is taken
    a_r7_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && hit_i && bo_i[4] && bo_i[2]) |-> taken);

    // R10: link write carries the return address
    a_r10_link_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && hit_i && lk_i) |-> (lr_we && lr_data == $past(pc_i) + ADDR_W'(INSN_STEP)));
endmodule

bind cbr_unit cbr_unit_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .INSN_STEP(INSN_STEP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (dec_hit),
    .bo_i      (instr[25:21]),
    .lk_i      (instr[0]),
    .pc_i      (pc),
    .ctr_i     (ctr),
    .out_valid (out_valid),
    .taken     (taken),
    .ctr_next  (ctr_next),
    .lr_we     (lr_we),
    .lr_data   (lr_data)
);

// File: tb/tb_cbr_unit.sv
// Self-checking bench for cbr_unit: vector table then directed cases.
module tb_cbr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc = '0;
    logic [31:0] cr = '0;
    logic [31:0] ctr = '0;
    logic        out_valid, taken, lr_we;
    logic [31:0] target, ctr_next, lr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cbr_unit dut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc), .cr(cr), .ctr(ctr),
        .out_valid(out_valid), .taken(taken), .target(target),
        .ctr_next(ctr_next), .lr_we(lr_we), .lr_data(lr_data)
    );

    typedef struct packed {
        logic [4:0]  bo;
        logic [4:0]  bi;
        logic [13:0] bd;
        logic        aa;
        logic        lk;
        logic [31:0] pc;
        logic [31:0] cr;
        logic [31:0] ctr;
        logic        etk;
        logic [31:0] ectr;
    } vec_t;

    localparam int NV = 16;
    // bo, bi, bd, aa, lk, pc, cr, ctr, expected taken, expected count
    localparam vec_t VECS [NV] = '{
        '{5'b00000, 5'd0,  14'h0010, 1'b0, 1'b0, 32'h0000_1000, 32'h0000_0000, 32'd3, 1'b1, 32'd2},  // R3 false, R5 nonzero
        '{5'b00000, 5'd0,  14'h3FFF, 1'b0, 1'b1, 32'h0000_2000, 32'h8000_0000, 32'd3, 1'b0, 32'd2},  // R3 fails, link still written
        '{5'b00010, 5'd0,  14'h0100, 1'b1, 1'b0, 32'h0000_3000, 32'h0000_0000, 32'd1, 1'b1, 32'd0},  // R5 zero test, 1 to 0
        '{5'b00010, 5'd0,  14'h2000, 1'b1, 1'b1, 32'h0000_4000, 32'h0000_0000, 32'd5, 1'b0, 32'd4},  // R5 zero test fails
        '{5'b00100, 5'd0,  14'h0004, 1'b0, 1'b1, 32'h0001_0000, 32'h0000_0000, 32'd7, 1'b1, 32'd7},  // condition only, false
        '{5'b00111, 5'd0,  14'h0004, 1'b0, 1'b0, 32'h0001_0000, 32'h0000_0000, 32'd7, 1'b1, 32'd7},  // R8 hint bits set
        '{5'b01000, 5'd2,  14'h1FFF, 1'b0, 1'b0, 32'h0000_8000, 32'h2000_0000, 32'd2, 1'b1, 32'd1},  // R3 true on index 2
        '{5'b01010, 5'd2,  14'h0040, 1'b1, 1'b1, 32'h0000_8000, 32'h2000_0000, 32'd1, 1'b1, 32'd0},  // true and zero
        '{5'b01100, 5'd31, 14'h0008, 1'b0, 1'b0, 32'hFFFF_FFF0, 32'h0000_0001, 32'd9, 1'b1, 32'd9},  // R2 index 31, wrap target
        '{5'b01100, 5'd31, 14'h0008, 1'b0, 1'b1, 32'h0000_0100, 32'hFFFF_FFFE, 32'd9, 1'b0, 32'd9},  // true required, bit clear
        '{5'b10000, 5'd0,  14'h0020, 1'b0, 1'b0, 32'h0000_5000, 32'h0000_0000, 32'd0, 1'b1, 32'hFFFF_FFFF}, // R4 wrap, nonzero
        '{5'b10010, 5'd0,  14'h0020, 1'b0, 1'b1, 32'h0000_5000, 32'h0000_0000, 32'd0, 1'b0, 32'hFFFF_FFFF}, // R4 wrap, zero fails
        '{5'b11010, 5'd0,  14'h0030, 1'b1, 1'b0, 32'h0000_6000, 32'h0000_0000, 32'd1, 1'b1, 32'd0},  // R8 bo[3] ignored
        '{5'b10100, 5'd0,  14'h3000, 1'b0, 1'b1, 32'h0000_7000, 32'h0000_0000, 32'd0, 1'b1, 32'd0},  // R7 always, count held
        '{5'b11111, 5'd5,  14'h0001, 1'b1, 1'b1, 32'h0000_7000, 32'h0000_0000, 32'h55, 1'b1, 32'h55}, // R7 always, all z set
        '{5'b10001, 5'd0,  14'h0002, 1'b0, 1'b0, 32'h0000_9000, 32'hFFFF_FFFF, 32'd2, 1'b1, 32'd1}   // R8 bo[0] hint
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_target(input logic [13:0] bd, input logic aa, input logic [31:0] p);
        logic [31:0] off;
        off = {{16{bd[13]}}, bd, 2'b00};
        return aa ? off : p + off;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: reset state
        rst_n = 1'b0;
        instr = {6'd16, 5'b10100, 5'd0, 14'h0010, 1'b0, 1'b1};
        pc = 32'h100; ctr = 32'd4;
        repeat (3) @(negedge clk);
        chk("R11", "out_valid", {31'b0, out_valid}, 32'd0);
        chk("R11", "taken", {31'b0, taken}, 32'd0);
        chk("R11", "lr_we", {31'b0, lr_we}, 32'd0);
        chk("R11", "ctr_next", ctr_next, 32'd0);
        chk("R11", "target", target, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R2 R3 R5 R6 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            instr = {6'd16, VECS[i].bo, VECS[i].bi, VECS[i].bd, VECS[i].aa, VECS[i].lk};
            pc = VECS[i].pc; cr = VECS[i].cr; ctr = VECS[i].ctr;
            @(negedge clk);
            chk("R1", "out_valid", {31'b0, out_valid}, 32'd1);
            chk("R6", "taken", {31'b0, taken}, {31'b0, VECS[i].etk});
            chk("R4", "ctr_next", ctr_next, VECS[i].ectr);
            chk("R9", "target", target, exp_target(VECS[i].bd, VECS[i].aa, VECS[i].pc));
            chk("R10", "lr_we", {31'b0, lr_we}, {31'b0, VECS[i].lk});
            if (VECS[i].lk)
                chk("R10", "lr_data", lr_data, VECS[i].pc + 32'd4);
        end

        // R1: other opcode leaves everything quiet and count passed through
        instr = {6'd18, 5'b10100, 5'd0, 14'h0010, 1'b0, 1'b1};
        pc = 32'h2000; ctr = 32'd12;
        @(negedge clk);
        chk("R1", "out_valid", {31'b0, out_valid}, 32'd0);
        chk("R1", "taken", {31'b0, taken}, 32'd0);
        chk("R1", "lr_we", {31'b0, lr_we}, 32'd0);
        chk("R1", "ctr_next", ctr_next, 32'd12);

        // R8: bo[1] ignored when bo[2]=1 (condition-only, false required)
        instr = {6'd16, 5'b00110, 5'd0, 14'h0010, 1'b0, 1'b0};
        cr = 32'h0; ctr = 32'd0;
        @(negedge clk);
        chk("R8", "taken", {31'b0, taken}, 32'd1);
        chk("R8", "ctr_next", ctr_next, 32'd0);

        // R11: reset after activity clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "out_valid", {31'b0, out_valid}, 32'd0);
        chk("R11", "taken", {31'b0, taken}, 32'd0);
        rst_n = 1'b1;
        instr = '0;
        @(negedge clk);
        finish_run();
    end
endmodule